// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Subtract and Multiply-Only Modes

This block multiplies two 16-bit signed two's-complement operands and, under a 2-bit operation code, either folds the product into a 40-bit running total (adding or subtracting it), shows the product alone without disturbing the total, or simply re-displays the total. The product is sign-extended to the accumulator width, so the eight upper bits act as guard bits that absorb several hundred worst-case products before the total can wrap.

Each operation is qualified by a valid strobe and takes effect on the rising clock edge. The result register then presents, one cycle later, the new total, the extended product, or the held total, according to the opcode. A synchronous clear zeroes the total, the result and a sticky overflow flag, and it beats any opcode presented in the same cycle. The overflow flag records any signed wrap of the 40-bit total and stays up until a clear or reset.

Top module: `smac_core`

## Requirements
- R1: While rst_ni is low at a rising edge, acc_o, result_o and ovf_o are zero after that edge.
- R2: With valid_i high, clr_i low and op_i = 2'b01, the edge adds the sign-extended signed product a_i*b_i to acc_o, and result_o shows the new acc_o.
- R3: With valid_i high, clr_i low and op_i = 2'b10, the edge subtracts the sign-extended signed product from acc_o, and result_o shows the new acc_o.
- R4: With valid_i high, clr_i low and op_i = 2'b11, result_o shows the 40-bit sign-extended product after the edge and acc_o keeps its value.
- R5: With valid_i high, clr_i low and op_i = 2'b00, acc_o keeps its value and result_o shows it after the edge.
- R6: With valid_i and clr_i low, acc_o, result_o and ovf_o do not change, whatever op_i, a_i and b_i carry.
- R7: With clr_i high, acc_o, result_o and ovf_o are zero after the edge, regardless of valid_i and op_i.
- R8: ovf_o rises after an add or subtract whose exact signed sum falls outside the range of a 40-bit signed number, and stays high until a clear or reset.
- R9: Operands are read as signed two's complement; -32768 times -32768 gives +2^30, and -1 times 32767 gives -32767.
- R10: An accumulation that overflows leaves acc_o holding the exact sum modulo 2^40.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of total, result and flag; highest priority |
| valid_i | input | 1 | Qualifies op_i and the operands for this edge |
| op_i | input | 2 | 00 hold/show total, 01 add product, 10 subtract product, 11 multiply only |
| a_i | input | 16 | Signed multiplicand |
| b_i | input | 16 | Signed multiplier |
| acc_o | output | 40 | Running signed total |
| result_o | output | 40 | Registered result: total or sign-extended product |
| ovf_o | output | 1 | Sticky signed overflow of the total |

## Verification
Short directed runs with small mixed-sign operands separate the add path from the subtract path and show that multiply-only and hold leave the total untouched. Extreme operands (-32768 squared, -1 by 32767) tell a signed multiplier apart from an unsigned one or a truncating sign extension. A run of 512 maximal products added from zero, then 513 subtracted, hits the exact positive and negative wrap points, separating a correct overflow test from an off-by-one one and showing that the flag stays set afterwards. A long random stream with occasional clears and idle cycles, compared every cycle against a behavioural model, exercises clear priority and the idle hold in mixed order.

// File: rtl/smac_pkg.sv
package smac_pkg;

   typedef enum logic [1:0] {
      OP_HOLD = 2'b00,
      OP_ADD  = 2'b01,
      OP_SUB  = 2'b10,
      OP_MUL  = 2'b11
   } smac_op_e;

   typedef struct packed {
      logic clear;
      logic acc_en;
      logic sub;
      logic load_prod;
      logic load_acc;
   } smac_ctl_t;

   localparam int MULT_ARCH_INFER    = 0;
   localparam int MULT_ARCH_SHIFTADD = 1;

endpackage

// File: rtl/smac_decode.sv
module smac_decode
   import smac_pkg::*;
(
   input  logic       clr_i,
   input  logic       valid_i,
   input  logic [1:0] op_i,
   output smac_ctl_t  ctl_o
);

   logic upd;
   smac_op_e op;

   assign op  = smac_op_e'(op_i);
   assign upd = valid_i & ~clr_i;

   always_comb begin
      ctl_o           = '0;
      ctl_o.clear     = clr_i;
      ctl_o.sub       = (op == OP_SUB);
      ctl_o.acc_en    = upd & ((op == OP_ADD) | (op == OP_SUB));
      ctl_o.load_prod = upd & (op == OP_MUL);
      ctl_o.load_acc  = upd & (op == OP_HOLD);
   end

endmodule

// File: rtl/smac_mult.sv
module smac_mult
   import smac_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ARCH   = MULT_ARCH_SHIFTADD,
   localparam int PROD_W = 2 * DATA_W
) (
   input  logic signed [DATA_W-1:0] a_i,
   input  logic signed [DATA_W-1:0] b_i,
   output logic signed [PROD_W-1:0] prod_o
);

   if (DATA_W < 2) begin : g_bad_w
      $error("smac_mult: DATA_W must be at least 2");
   end

   if (ARCH == MULT_ARCH_INFER) begin : g_infer
      assign prod_o = a_i * b_i;
   end else if (ARCH == MULT_ARCH_SHIFTADD) begin : g_shiftadd
      localparam logic [PROD_W-1:0] ONE = PROD_W'(1);
      logic [PROD_W-1:0] a_ext;
      logic [PROD_W-1:0] pp [DATA_W];
      logic [PROD_W-1:0] total;

      assign a_ext = {{DATA_W{a_i[DATA_W-1]}}, a_i};

      for (genvar i = 0; i < DATA_W; i++) begin : g_pp
         if (i == DATA_W - 1) begin : g_neg
            // the top bit of b carries negative weight
            assign pp[i] = b_i[i] ? (~(a_ext << i) + ONE) : '0;
         end else begin : g_pos
            assign pp[i] = b_i[i] ? (a_ext << i) : '0;
         end
      end

      always_comb begin
         total = '0;
         for (int k = 0; k < DATA_W; k++) begin
            total = total + pp[k];
         end
      end

      assign prod_o = $signed(total);
   end else begin : g_bad_arch
      $error("smac_mult: unknown ARCH");
   end

endmodule

// File: rtl/smac_addsub.sv
module smac_addsub #(
   parameter int ACC_W = 40
) (
   input  logic [ACC_W-1:0] acc_i,
   input  logic [ACC_W-1:0] opd_i,
   input  logic             sub_i,
   output logic [ACC_W-1:0] sum_o,
   output logic             ovf_o
);

   logic [ACC_W-1:0] opd_x;

   // subtraction as add of the inverted operand plus one
   assign opd_x = sub_i ? ~opd_i : opd_i;
   assign sum_o = acc_i + opd_x + ACC_W'(sub_i);
   assign ovf_o = (acc_i[ACC_W-1] == opd_x[ACC_W-1]) &&
                  (sum_o[ACC_W-1] != acc_i[ACC_W-1]);

endmodule

// File: rtl/smac_core.sv
module smac_core
   import smac_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ACC_W     = 40,
   parameter int MULT_ARCH = MULT_ARCH_SHIFTADD
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clr_i,
   input  logic              valid_i,
   input  logic [1:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [ACC_W-1:0]  acc_o,
   output logic [ACC_W-1:0]  result_o,
   output logic              ovf_o
);

   localparam int PROD_W  = 2 * DATA_W;
   localparam int GUARD_W = ACC_W - PROD_W;

   if (ACC_W <= PROD_W) begin : g_bad_acc
      $error("smac_core: ACC_W must exceed twice DATA_W to leave guard bits");
   end

   smac_ctl_t                ctl;
   logic signed [PROD_W-1:0] prod;
   logic [ACC_W-1:0]         prod_ext;
   logic [ACC_W-1:0]         sum;
   logic                     sum_ovf;
   logic [ACC_W-1:0]         acc_q;
   logic [ACC_W-1:0]         res_q;
   logic                     ovf_q;

   smac_decode u_dec (
      .clr_i   (clr_i),
      .valid_i (valid_i),
      .op_i    (op_i),
      .ctl_o   (ctl)
   );

   smac_mult #(
      .DATA_W (DATA_W),
      .ARCH   (MULT_ARCH)
   ) u_mult (
      .a_i    ($signed(a_i)),
      .b_i    ($signed(b_i)),
      .prod_o (prod)
   );

   assign prod_ext = {{GUARD_W{prod[PROD_W-1]}}, prod};

   smac_addsub #(
      .ACC_W (ACC_W)
   ) u_as (
      .acc_i (acc_q),
      .opd_i (prod_ext),
      .sub_i (ctl.sub),
      .sum_o (sum),
      .ovf_o (sum_ovf)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni || ctl.clear) begin
         acc_q <= '0;
         res_q <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (ctl.acc_en) begin
            acc_q <= sum;
            res_q <= sum;
            ovf_q <= ovf_q | sum_ovf;
         end else if (ctl.load_prod) begin
            res_q <= prod_ext;
         end else if (ctl.load_acc) begin
            res_q <= acc_q;
         end
      end
   end

   assign acc_o    = acc_q;
   assign result_o = res_q;
   assign ovf_o    = ovf_q;

endmodule

// File: rtl/smac_core_chk.sv
module smac_core_chk #(
   parameter int DATA_W = 16,
   parameter int ACC_W  = 40
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              clr_i,
   input logic              valid_i,
   input logic [1:0]        op_i,
   input logic [DATA_W-1:0] a_i,
   input logic [DATA_W-1:0] b_i,
   input logic [ACC_W-1:0]  acc_o,
   input logic [ACC_W-1:0]  result_o,
   input logic              ovf_o
);

   logic signed [ACC_W-1:0] a_x;
   logic signed [ACC_W-1:0] b_x;
   logic [ACC_W-1:0]        prod_x;
   logic                    go;

   assign a_x    = ACC_W'($signed(a_i));
   assign b_x    = ACC_W'($signed(b_i));
   assign prod_x = a_x * b_x;
   assign go     = valid_i && !clr_i;

   AST_ADD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (go && op_i == 2'b01) |=> (acc_o == $past(acc_o + prod_x)) && (result_o == acc_o)); // R2

   AST_SUB_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (go && op_i == 2'b10) |=> (acc_o == $past(acc_o - prod_x)) && (result_o == acc_o)); // R3

   AST_MUL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (go && op_i == 2'b11) |=> (result_o == $past(prod_x)) && $stable(acc_o)); // R4

   AST_HOLD_SHOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (go && op_i == 2'b00) |=> (result_o == acc_o) && $stable(acc_o)); // R5

   AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!valid_i && !clr_i) |=> $stable(acc_o) && $stable(result_o) && $stable(ovf_o)); // R6

   AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (acc_o == '0) && (result_o == '0) && !ovf_o); // R7

   AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_o && !clr_i) |=> ovf_o); // R8

endmodule

bind smac_core smac_core_chk #(
   .DATA_W (DATA_W),
   .ACC_W  (ACC_W)
) u_chk (.*);

// File: tb/smac_core_bench.sv
`timescale 1ns/1ps
module smac_core_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        valid = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [15:0] a = '0;
   logic [15:0] b = '0;
   logic [39:0] acc;
   logic [39:0] res;
   logic        ovf;

   int checks = 0;
   int errors = 0;

   logic signed [39:0] m_acc = '0;
   logic [39:0]        m_res = '0;
   logic               m_ovf = 1'b0;

   always #10 clk = ~clk;

   smac_core u_smac_core (
      .clk_i    (clk),
      .rst_ni   (rst_n),
      .clr_i    (clr),
      .valid_i  (valid),
      .op_i     (op),
      .a_i      (a),
      .b_i      (b),
      .acc_o    (acc),
      .result_o (res),
      .ovf_o    (ovf)
   );

   task automatic compare(input string tag);
      checks++;
      if (acc !== m_acc) begin
         errors++;
         $display("FAIL %s acc actual %h expected %h", tag, acc, m_acc);
      end
      checks++;
      if (res !== m_res) begin
         errors++;
         $display("FAIL %s result actual %h expected %h", tag, res, m_res);
      end
      checks++;
      if (ovf !== m_ovf) begin
         errors++;
         $display("FAIL %s ovf actual %b expected %b", tag, ovf, m_ovf);
      end
   endtask

   task automatic model(input logic c, input logic v, input logic [1:0] o,
                        input logic [15:0] x, input logic [15:0] y);
      longint p, s, hi, lo;
      p  = longint'($signed(x)) * longint'($signed(y));
      hi = (longint'(1) <<< 39) - 1;
      lo = -(longint'(1) <<< 39);
      if (c) begin
         m_acc = '0; m_res = '0; m_ovf = 1'b0;
      end else if (v) begin
         case (o)
            2'b01, 2'b10: begin
               s = (o == 2'b01) ? longint'(m_acc) + p : longint'(m_acc) - p;
               if (s > hi || s < lo) m_ovf = 1'b1;
               m_acc = s[39:0];
               m_res = s[39:0];
            end
            2'b11:   m_res = p[39:0];
            default: m_res = m_acc;
         endcase
      end
   endtask

   task automatic step(input logic c, input logic v, input logic [1:0] o,
                       input logic [15:0] x, input logic [15:0] y, input string tag);
      clr = c; valid = v; op = o; a = x; b = y;
      @(posedge clk);
      model(c, v, o, x, y);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R1: reset state, with live inputs that must be ignored
      valid = 1'b1; op = 2'b01; a = 16'd100; b = 16'd100;
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare("R1 reset");
      rst_n = 1'b1;
      valid = 1'b0;

      // R2 / R3 small mixed-sign values
      step(0, 1, 2'b01, 16'd3, 16'd4, "R2 add 3*4");
      step(0, 1, 2'b01, -16'sd5, 16'd7, "R2 add -5*7");
      step(0, 1, 2'b10, 16'd100, -16'sd2, "R3 sub 100*-2");
      step(0, 1, 2'b10, 16'd9, 16'd9, "R3 sub 9*9");
      // R4 / R9 multiply only with extreme operands
      step(0, 1, 2'b11, 16'h8000, 16'h8000, "R4 R9 mul -32768^2");
      step(0, 1, 2'b11, 16'hFFFF, 16'd32767, "R4 R9 mul -1*32767");
      step(0, 1, 2'b11, 16'h7FFF, 16'h8000, "R4 R9 mul max*min");
      // R5 hold shows total
      step(0, 1, 2'b00, 16'd55, 16'd66, "R5 hold");
      // R6 idle with every opcode
      for (int k = 0; k < 4; k++) step(0, 0, 2'(k), 16'h1234, 16'h4321, "R6 idle");
      // R7 clear beats every opcode
      for (int k = 0; k < 4; k++) begin
         step(0, 1, 2'b01, 16'd1000, 16'd1000, "R2 preload");
         step(1, 1, 2'(k), 16'd77, 16'd88, "R7 clear priority");
      end
      step(1, 0, 2'b00, 16'd0, 16'd0, "R7 clear idle");

      // R8 / R10 positive wrap: 512 adds of 2^30 reach 2^39
      for (int k = 0; k < 512; k++) step(0, 1, 2'b01, 16'h8000, 16'h8000, "R8 R10 pos wrap");
      step(0, 1, 2'b10, 16'd1, 16'd1, "R8 sticky sub");
      step(0, 1, 2'b11, 16'd2, 16'd3, "R8 sticky mul");
      step(0, 0, 2'b00, 16'd0, 16'd0, "R8 sticky idle");
      step(1, 0, 2'b00, 16'd0, 16'd0, "R8 R7 clear flag");
      // negative wrap: 512 subtracts reach -2^39 exactly, the 513th wraps
      for (int k = 0; k < 513; k++) step(0, 1, 2'b10, 16'h8000, 16'h8000, "R8 R10 neg wrap");
      step(1, 0, 2'b00, 16'd0, 16'd0, "R7 clear");

      // mixed random stream
      for (int k = 0; k < 3000; k++) begin
         logic rc, rv;
         rc = ($urandom_range(63) == 0);
         rv = ($urandom_range(3) != 0);
         step(rc, rv, 2'($urandom_range(3)), 16'($urandom), 16'($urandom),
              "R2 R3 R4 R5 R6 R7 random");
      end

      finish_run();
   end

endmodule